// File: doc/BRIEF.md
# Inverted Serial Burst Transmitter

This block sends a fixed eight-byte message as an asynchronous serial waveform whose line levels are inverted: the idle/mark level drives the pin low and the space level drives it high. Timing comes from a free-running tick counter and a single compare target. Each time the counter reaches the target, the sequencer moves the line to its next level and pushes the target forward by one bit period. Edges are always placed relative to the previous target, never to "now", so rounding errors do not accumulate. The default bit period is the tick rate divided by the baud rate (1 MHz / 38400 = 26 ticks after truncation).

While idle, the compare target keeps moving 127 ticks ahead at every match. A start strobe arms a pending request and takes a snapshot of the message. The start bit of byte 0 goes out at the next compare match. After the stop bit of the eighth byte, the line stays at mark for a gap of 1000 ticks, measured from that match. The block then returns to idle, lowers busy and pulses done for one clock.

Top module: `inv_burst_tx`

## Requirements
- R1: After reset, line_o, busy_o and done_o are all 0.
- R2: Line levels are inverted. Idle, stop bits and data bits of value 1 drive line_o to 0. Start bits and data bits of value 0 drive line_o to 1. Whenever busy_o is low, line_o is 0.
- R3: Each byte goes out as one start bit, then its eight data bits with bit 0 first, then one stop bit. Byte n is taken from msg_i[8n+7:8n], and byte 0 is sent first, up to byte 7.
- R4: Every bit holds the line for exactly BIT_TICKS ticks (26 by default). Each edge is scheduled by adding the bit period to the previous compare target, so the 80 bits of a burst span exactly 80*BIT_TICKS ticks. The line changes only in the clock after a compare match.
- R5: While idle, the compare target moves IDLE_REARM (127) ticks ahead at each match. The start bit after a strobe begins at the next such match, no more than IDLE_REARM ticks after the strobe.
- R6: msg_i is captured on the accepted start strobe. Later changes to msg_i have no effect on the burst in flight.
- R7: After the last stop bit, line_o stays 0 for GAP_TICKS (1000) ticks. done_o then pulses high for exactly one clock, (80*BIT_TICKS + GAP_TICKS)*TICK_DIV clocks after the start bit's rising edge.
- R8: busy_o rises in the clock after an accepted start strobe and falls in the same clock that done_o is high.
- R9: A start strobe that arrives while busy_o is high is ignored. It does not start a second burst and does not extend busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-clock start strobe |
| msg_i | input | MSG_BYTES*8 | Message buffer; byte 0 in the low bits |
| line_o | output | 1 | Inverted serial line |
| busy_o | output | 1 | Burst pending, in progress, or in its idle gap |
| done_o | output | 1 | One-clock pulse when the block returns to idle |

## Verification
Two cases are hard to reach from the ports: a strobe that lands in the middle of a burst, and a message buffer that changes after it has been accepted. The stimulus raises start_i again halfway through the fourth byte with a different message on msg_i. From the cycle after each strobe it also drives the inverted message onto msg_i. The bench then checks every bit against the original message, and it watches the line and busy_o for hundreds of ticks after done_o to confirm that no second burst begins. The start latency depends on where the free-running idle re-arm schedule happens to be. Strobes are therefore issued at random offsets, which puts them at different points in the 127-tick idle window.

// File: rtl/ibt_pkg.sv
package ibt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_GAP
  } tx_state_e;
endpackage

// File: rtl/ibt_tick_div.sv
module ibt_tick_div #(
  parameter int TICK_DIV = 100
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [PW-1:0] pre_q;
      assign tick_o = (pre_q == PW'(TICK_DIV - 1));
      always_ff @(posedge clk) begin
        if (rst)         pre_q <= '0;
        else if (tick_o) pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/ibt_cmp_timer.sv
module ibt_cmp_timer #(
  parameter int CNT_W     = 16,
  parameter int RESET_TGT = 127
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             rearm_i,
  input  logic             from_now_i,
  input  logic [CNT_W-1:0] delta_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] tgt_o
);
  logic [CNT_W-1:0] now_q;
  logic [CNT_W-1:0] tgt_q;
  logic [CNT_W-1:0] base;

  assign hit_o = tick_i && (now_q == tgt_q);
  assign tgt_o = tgt_q;
  assign base  = from_now_i ? now_q : tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q <= '0;
      tgt_q <= CNT_W'(RESET_TGT);
    end else begin
      if (tick_i)  now_q <= now_q + 1'b1;
      if (rearm_i) tgt_q <= base + delta_i;
    end
  end
endmodule

// File: rtl/ibt_burst_seq.sv
module ibt_burst_seq
  import ibt_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int MSG_BYTES  = 8,
  parameter int BIT_TICKS  = 26,
  parameter int GAP_TICKS  = 1000,
  parameter int IDLE_REARM = 127,
  parameter bit INVERT     = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic [MSG_BYTES*8-1:0] msg_i,
  input  logic                   hit_i,
  output logic                   rearm_o,
  output logic                   from_now_o,
  output logic [CNT_W-1:0]       delta_o,
  output logic                   line_o,
  output logic                   busy_o,
  output logic                   done_o
);
  localparam int IDX_W = (MSG_BYTES > 1) ? $clog2(MSG_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MSG_BYTES - 1);
  localparam logic MARK_PIN  = INVERT ? 1'b0 : 1'b1;
  localparam logic SPACE_PIN = ~MARK_PIN;

  tx_state_e        st_q;
  logic             pend_q;
  logic             busy_q;
  logic             done_q;
  logic             pin_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_nxt;
  logic [3:0]       bitn_q;
  logic [7:0]       sh_q;
  logic [7:0]       store_q [MSG_BYTES];

  assign idx_nxt = idx_q + 1'b1;
  assign line_o  = pin_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;

  function automatic logic pin_of(input logic b);
    return INVERT ? ~b : b;
  endfunction

  // Next compare target selection
  always_comb begin
    rearm_o    = hit_i;
    from_now_o = 1'b0;
    delta_o    = CNT_W'(BIT_TICKS);
    unique case (st_q)
      ST_IDLE: begin
        if (!pend_q) begin
          from_now_o = 1'b1;
          delta_o    = CNT_W'(IDLE_REARM);
        end
      end
      ST_STOP: begin
        if (idx_q == LAST_IDX) begin
          from_now_o = 1'b1;
          delta_o    = CNT_W'(GAP_TICKS);
        end
      end
      ST_GAP: begin
        from_now_o = 1'b1;
        delta_o    = CNT_W'(IDLE_REARM);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pin_q  <= MARK_PIN;
      idx_q  <= '0;
      bitn_q <= '0;
      sh_q   <= '0;
      for (int i = 0; i < MSG_BYTES; i++) store_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        pend_q <= 1'b1;
        for (int i = 0; i < MSG_BYTES; i++) store_q[i] <= msg_i[i*8 +: 8];
      end
      if (hit_i) begin
        unique case (st_q)
          ST_IDLE: begin
            if (pend_q) begin
              pend_q <= 1'b0;
              idx_q  <= '0;
              sh_q   <= store_q[0];
              pin_q  <= SPACE_PIN;
              st_q   <= ST_START;
            end
          end
          ST_START: begin
            pin_q  <= pin_of(sh_q[0]);
            sh_q   <= sh_q >> 1;
            bitn_q <= 4'd1;
            st_q   <= ST_DATA;
          end
          ST_DATA: begin
            if (bitn_q == 4'd8) begin
              pin_q <= MARK_PIN;
              st_q  <= ST_STOP;
            end else begin
              pin_q  <= pin_of(sh_q[0]);
              sh_q   <= sh_q >> 1;
              bitn_q <= bitn_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (idx_q == LAST_IDX) begin
              st_q <= ST_GAP;
            end else begin
              idx_q <= idx_nxt;
              sh_q  <= store_q[idx_nxt];
              pin_q <= SPACE_PIN;
              st_q  <= ST_START;
            end
          end
          ST_GAP: begin
            st_q   <= ST_IDLE;
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/inv_burst_tx.sv
module inv_burst_tx #(
  parameter int TICK_DIV   = 100,
  parameter int TICK_HZ    = 1000000,
  parameter int BAUD       = 38400,
  parameter int CNT_W      = 16,
  parameter int MSG_BYTES  = 8,
  parameter int GAP_TICKS  = 1000,
  parameter int IDLE_REARM = 127,
  parameter bit INVERT     = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic [MSG_BYTES*8-1:0] msg_i,
  output logic                   line_o,
  output logic                   busy_o,
  output logic                   done_o
);
  localparam int BIT_TICKS = TICK_HZ / BAUD;

  logic             tick_w;
  logic             hit_w;
  logic             rearm_w;
  logic             from_now_w;
  logic [CNT_W-1:0] delta_w;
  logic [CNT_W-1:0] tgt_w;

  ibt_tick_div #(.TICK_DIV(TICK_DIV)) div_i (
    .clk(clk), .rst(rst), .tick_o(tick_w)
  );

  ibt_cmp_timer #(.CNT_W(CNT_W), .RESET_TGT(IDLE_REARM)) tmr_i (
    .clk(clk), .rst(rst), .tick_i(tick_w), .rearm_i(rearm_w),
    .from_now_i(from_now_w), .delta_i(delta_w), .hit_o(hit_w), .tgt_o(tgt_w)
  );

  ibt_burst_seq #(
    .CNT_W(CNT_W), .MSG_BYTES(MSG_BYTES), .BIT_TICKS(BIT_TICKS),
    .GAP_TICKS(GAP_TICKS), .IDLE_REARM(IDLE_REARM), .INVERT(INVERT)
  ) seq_i (
    .clk(clk), .rst(rst), .start_i(start_i), .msg_i(msg_i), .hit_i(hit_w),
    .rearm_o(rearm_w), .from_now_o(from_now_w), .delta_o(delta_w),
    .line_o(line_o), .busy_o(busy_o), .done_o(done_o)
  );
endmodule

// File: rtl/ibt_chk.sv
module ibt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             line_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             hit_i,
  input logic [CNT_W-1:0] tgt_i
);
  // R2
  idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !line_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  // R4
  edge_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    (line_o != $past(line_o)) |-> $past(hit_i));

  // R5
  target_moves_chk: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> (tgt_i != $past(tgt_i)));
endmodule

bind inv_burst_tx ibt_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .line_o(line_o),
  .busy_o(busy_o), .done_o(done_o), .hit_i(hit_w), .tgt_i(tgt_w)
);

// File: tb/inv_burst_tx_tb_top.sv
`timescale 1ns/1ps
module inv_burst_tx_tb_top;
  localparam int DIV   = 2;
  localparam int BITT  = 26;
  localparam int GAP   = 1000;
  localparam int REARM = 127;
  localparam int NBITS = 80;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] msg = '0;
  logic        line, busy, done;
  int          cyc = 0;
  int          errs = 0;
  int          checks = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  inv_burst_tx #(.TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .msg_i(msg),
    .line_o(line), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // Expected pin level of bit k of a burst (inverted line)
  function automatic logic exp_pin(input logic [63:0] m, input int k);
    int b, by;
    b  = k % 10;
    by = k / 10;
    if (b == 0) return 1'b1;
    if (b == 9) return 1'b0;
    return ~m[by*8 + b - 1];
  endfunction

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic burst(input logic [63:0] m, input bit disturb);
    int n, t0, s;
    bit busy_ok;
    msg = m;
    @(negedge clk);
    start = 1'b1;
    s = cyc;
    @(negedge clk);
    start = 1'b0;
    msg = ~m;                       // R6: buffer changes after capture
    chk(busy === 1'b1, "R8", "busy after strobe", busy, 1);
    n = 0;
    busy_ok = 1'b1;
    while (line !== 1'b1 && n < (REARM + 4) * DIV) begin
      if (busy !== 1'b1) busy_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    chk(busy_ok, "R8", "busy while pending", busy_ok, 1);
    chk(line === 1'b1 && (cyc - s) <= (REARM + 1) * DIV + 2, "R5",
        "start latency cycles", cyc - s, (REARM + 1) * DIV);
    t0 = cyc;
    for (int k = 0; k < NBITS; k++) begin
      wait_cyc(t0 + k * BITT * DIV + (BITT / 2) * DIV);
      chk(line === exp_pin(m, k), "R3", $sformatf("bit %0d level", k),
          line, exp_pin(m, k));
      if (disturb && k == 35) begin
        start = 1'b1;               // R9: strobe while busy
        msg = {m[31:0], m[63:32]} ^ 64'hA5A5_5A5A_0F0F_F0F0;
        @(negedge clk);
        start = 1'b0;
      end
    end
    // R4: last stop bit still at mark right before boundary, span exact
    wait_cyc(t0 + NBITS * BITT * DIV - 1);
    chk(line === 1'b0 && busy === 1'b1, "R4", "last stop bit end", line, 0);
    wait_cyc(t0 + (NBITS * BITT + GAP / 2) * DIV);
    chk(line === 1'b0 && busy === 1'b1, "R7", "gap holds mark", line, 0);
    wait_cyc(t0 + (NBITS * BITT + GAP) * DIV - 1);
    chk(done === 1'b0 && busy === 1'b1, "R7", "done early", done, 0);
    @(negedge clk);
    chk(done === 1'b1, "R7", "done at gap end", done, 1);
    chk(busy === 1'b0, "R8", "busy falls with done", busy, 0);
    @(negedge clk);
    chk(done === 1'b0, "R7", "done single pulse", done, 0);
  endtask

  task automatic quiet_window(input int ncyc, input string req);
    bit ok = 1'b1;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (line !== 1'b0 || busy !== 1'b0 || done !== 1'b0) ok = 1'b0;
    end
    chk(ok, req, "line/busy quiet after burst", ok, 1);
  endtask

  initial begin
    #(4 * 190000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [63:0] r;
    void'($urandom(32'h1BD7));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(line === 1'b0, "R1", "line at reset", line, 0);
    chk(busy === 1'b0, "R1", "busy at reset", busy, 0);
    chk(done === 1'b0, "R1", "done at reset", done, 0);
    // R2: idle line stays low without strobe
    quiet_window(300, "R2");

    burst(64'h0000_0000_0000_0000, 1'b0);
    burst(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    burst(64'h55AA_55AA_0102_8040, 1'b1);
    quiet_window(400 * DIV, "R9");
    for (int i = 0; i < 5; i++) begin
      r = {$urandom, $urandom};
      repeat ($urandom_range(1, 300)) @(negedge clk);
      burst(r, (i == 2));
      if (i == 2) quiet_window(300 * DIV, "R9");
    end
    report();
  end
endmodule